// File: doc/BRIEF.md
# Masked Burst Write Datapath

This block models the write side of one bank of a synchronous graphics memory, sized to a small internal array. A write command starts a four-beat burst. Each following cycle that carries no new command writes the next beat to the next column. The column steps through a four-column aligned group and wraps inside it. Every stored bit is changed only when both of these allow it: the matching bit of an 8-bit per-bit mask register, and the per-byte data mask for that beat.

A burst still in progress can be cut short. Another write, a block write, a precharge, a precharge-all, a read or a mask load each stops it. The block write puts one masked data word into all four columns of an aligned group in a single cycle. The read returns a stored word one cycle after its command. The host keeps write data off the bus for at least one cycle before read data is due, so the read is only issued after the last beat it wants has been registered.

Top module: `masked_burst_writer`

## Requirements
- R1: After reset, `busy_o` and `rd_valid_o` are 0, the mask register is all ones (every bit writable), and every column reads back as zero.
- R2: A write command (cmd code 1) writes beat 0 to `col_i` in its own cycle. Each later cycle with cmd NOP (code 0) writes the next beat with the same upper column bits. The two low column bits step up by one modulo 4 from the start column.
- R3: A burst writes exactly four beats. `busy_o` is 1 from the edge after the write command until the edge that writes the fourth beat. NOP cycles after that write nothing.
- R4: A mask load (cmd code 6) loads `data_i[7:0]` into the mask register. Mask bit j governs data bit j of every byte lane: 1 lets the new bit in, 0 keeps the stored bit. The value holds until the next mask load and applies from the following cycle.
- R5: When `dqm_i[l]` is 1, byte lane l (data bits 8l+7..8l) is not written for that beat, whatever the mask register holds.
- R6: A write command issued while a burst is in progress abandons the old burst. The new burst starts at the new column, and its beat 0 is written in the command cycle.
- R7: A read (cmd code 5) ends any burst and writes nothing in its own cycle. On the next cycle, `rd_valid_o` is 1 and `rd_data_o` holds the word stored at `col_i`. `rd_data_o` keeps that value until the next read.
- R8: A precharge (code 3) or precharge-all (code 4) ends any burst. No beat is written in that cycle or afterwards.
- R9: A block write (code 2) ends any burst. In its own cycle, it writes the masked `data_i` into all four columns that share the upper column bits of `col_i`.
- R10: A mask load, or the unused code 7, also ends any burst without writing data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command: 0 NOP, 1 write, 2 block write, 3 precharge, 4 precharge-all, 5 read, 6 mask load, 7 unused |
| col_i | input | COL_W | Column address for the command |
| data_i | input | 8*LANES | Write data for the beat; low byte is the mask value on a mask load |
| dqm_i | input | LANES | Per-byte write block, active high |
| busy_o | output | 1 | A write burst has beats left |
| rd_data_o | output | 8*LANES | Word returned by the last read |
| rd_valid_o | output | 1 | rd_data_o was loaded by the read in the previous cycle |

## Verification
The first patterns are uninterrupted bursts from start columns at each offset inside the aligned group. These show whether the column wraps inside the group or carries into the upper bits. Mask patterns with alternating bits and partial byte blocks show the bit-lane mapping of the mask register and whether the byte mask overrides it. Interrupts at each beat position, by every command kind, show exactly which beat is the last one written. A long mixed run of random commands, followed by reading every column, catches any stray write.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_WRITE  = 3'd1,
    CMD_BLKWR  = 3'd2,
    CMD_PRE    = 3'd3,
    CMD_PREALL = 3'd4,
    CMD_READ   = 3'd5,
    CMD_MASKLD = 3'd6,
    CMD_RSVD   = 3'd7
  } cmd_e;
endpackage

// File: rtl/mbw_burst_ctrl.sv
module mbw_burst_ctrl
  import mbw_pkg::*;
#(
  parameter int COL_W     = 6,
  parameter int BURST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic [COL_W-1:0] col_i,
  output logic             wr_vld_o,
  output logic             blk_o,
  output logic [COL_W-1:0] wr_col_o,
  output logic             busy_o
);
  localparam int LOW_W = $clog2(BURST_LEN);
  localparam logic [LOW_W-1:0] LAST = LOW_W'(BURST_LEN - 1);

  logic             active_q;
  logic [LOW_W-1:0] cnt_q;
  logic [COL_W-1:0] base_q;
  logic [LOW_W-1:0] lo;

  assign lo = base_q[LOW_W-1:0] + cnt_q;

  always_comb begin
    wr_vld_o = 1'b0;
    blk_o    = 1'b0;
    wr_col_o = col_i;
    if (cmd_i == CMD_WRITE) begin
      wr_vld_o = 1'b1;
    end else if (cmd_i == CMD_BLKWR) begin
      wr_vld_o = 1'b1;
      blk_o    = 1'b1;
    end else if (cmd_i == CMD_NOP && active_q) begin
      wr_vld_o = 1'b1;
      wr_col_o = {base_q[COL_W-1:LOW_W], lo};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
    end else if (cmd_i == CMD_WRITE) begin
      active_q <= 1'b1;
      cnt_q    <= LOW_W'(1);
      base_q   <= col_i;
    end else if (cmd_i == CMD_NOP) begin
      if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) active_q <= 1'b0;
      end
    end else begin
      active_q <= 1'b0;  // any other command cuts the burst
    end
  end

  assign busy_o = active_q;

  // R3
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cmd_i == CMD_NOP && cnt_q == LAST) |=> !active_q);
  // R2
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cmd_i == CMD_NOP && cnt_q != LAST) |=> (active_q && cnt_q == $past(cnt_q) + 1'b1));
  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_WRITE) |=> (active_q && base_q == $past(col_i)));
  // R8
  precharge_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PRE || cmd_i == CMD_PREALL) |=> !active_q);
endmodule

// File: rtl/mbw_mask_merge.sv
module mbw_mask_merge #(
  parameter int LANES = 4
) (
  input  logic [7:0]         bitmask_i,
  input  logic [LANES-1:0]   dqm_i,
  output logic [8*LANES-1:0] en_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign en_o[8*l +: 8] = bitmask_i & {8{~dqm_i[l]}};
  end

  // R5
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      if (dqm_i[l]) lane_block_chk: assert (en_o[8*l +: 8] == 8'h00);
    end
  end
endmodule

// File: rtl/mbw_array.sv
module mbw_array #(
  parameter int COL_W = 6,
  parameter int DW    = 32,
  parameter int LOW_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_vld_i,
  input  logic             blk_i,
  input  logic [COL_W-1:0] wr_col_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [DW-1:0]    wr_en_i,
  input  logic             rd_vld_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o
);
  localparam int DEPTH = 1 << COL_W;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_vld_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (blk_i ? (COL_W'(i) >> LOW_W) == (wr_col_i >> LOW_W) : COL_W'(i) == wr_col_i)
          mem_q[i] <= (mem_q[i] & ~wr_en_i) | (wr_data_i & wr_en_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_vld_i;
      if (rd_vld_i) rd_data_o <= mem_q[rd_col_i];
    end
  end

  // R7
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_vld_i |=> $stable(rd_data_o));
endmodule

// File: rtl/masked_burst_writer.sv
module masked_burst_writer
  import mbw_pkg::*;
#(
  parameter int COL_W     = 6,
  parameter int LANES     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         cmd_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic [8*LANES-1:0] data_i,
  input  logic [LANES-1:0]   dqm_i,
  output logic               busy_o,
  output logic [8*LANES-1:0] rd_data_o,
  output logic               rd_valid_o
);
  localparam int DW    = 8 * LANES;
  localparam int LOW_W = $clog2(BURST_LEN);

  cmd_e             cmd;
  logic [7:0]       bitmask_q;
  logic             wr_vld, blk;
  logic [COL_W-1:0] wr_col;
  logic [DW-1:0]    wr_en;

  assign cmd = cmd_e'(cmd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 bitmask_q <= 8'hFF;
    else if (cmd == CMD_MASKLD)  bitmask_q <= data_i[7:0];
  end

  mbw_burst_ctrl #(.COL_W(COL_W), .BURST_LEN(BURST_LEN)) u_ctrl (
    .clk_i, .rst_ni, .cmd_i(cmd), .col_i,
    .wr_vld_o(wr_vld), .blk_o(blk), .wr_col_o(wr_col), .busy_o
  );

  mbw_mask_merge #(.LANES(LANES)) u_merge (
    .bitmask_i(bitmask_q), .dqm_i, .en_o(wr_en)
  );

  mbw_array #(.COL_W(COL_W), .DW(DW), .LOW_W(LOW_W)) u_array (
    .clk_i, .rst_ni,
    .wr_vld_i(wr_vld), .blk_i(blk), .wr_col_i(wr_col),
    .wr_data_i(data_i), .wr_en_i(wr_en),
    .rd_vld_i(cmd == CMD_READ), .rd_col_i(col_i),
    .rd_data_o, .rd_valid_o
  );

  // R7
  read_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_READ) |-> !wr_vld);
  // R7
  read_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_READ) |=> rd_valid_o);
  // R10
  maskld_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_MASKLD || cmd == CMD_RSVD) |=> !busy_o);
  // R4
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != CMD_MASKLD) |=> $stable(bitmask_q));
endmodule

// File: tb/sim_masked_burst_writer.sv
module sim_masked_burst_writer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic [5:0]  col_i = '0;
  logic [31:0] data_i = '0;
  logic [3:0]  dqm_i = '0;
  logic        busy_o, rd_valid_o;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  masked_burst_writer u0 (.*);

  // reference model state
  logic [31:0] m_mem [64];
  logic [7:0]  m_mask;
  bit          m_act;
  int          m_base, m_cnt;
  logic [31:0] m_rd;
  bit          m_rdv;

  function automatic void m_write(int col, logic [31:0] d, logic [3:0] dq);
    for (int b = 0; b < 32; b++)
      if (m_mask[b % 8] && !dq[b / 8]) m_mem[col][b] = d[b];
  endfunction

  task automatic model(logic [2:0] c, int col, logic [31:0] d, logic [3:0] dq);
    m_rdv = 0;
    if (c == 3'd1) begin
      m_write(col, d, dq); m_act = 1; m_base = col; m_cnt = 1;
    end else if (c == 3'd0) begin
      if (m_act) begin
        m_write((m_base & ~3) | ((m_base + m_cnt) & 3), d, dq);
        m_cnt++;
        if (m_cnt == 4) m_act = 0;
      end
    end else begin
      m_act = 0;
      if (c == 3'd2) for (int k = 0; k < 4; k++) m_write((col & ~3) | k, d, dq);
      if (c == 3'd5) begin m_rdv = 1; m_rd = m_mem[col]; end
      if (c == 3'd6) m_mask = d[7:0];
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [2:0] c, int col, logic [31:0] d, logic [3:0] dq, string req);
    cmd_i = c; col_i = col[5:0]; data_i = d; dqm_i = dq;
    @(posedge clk_i);
    model(c, col, d, dq);
    @(negedge clk_i);
    check({req, " busy"}, {31'd0, busy_o}, {31'd0, m_act});
    check({req, " rd_valid"}, {31'd0, rd_valid_o}, {31'd0, m_rdv});
    if (m_rdv) check({req, " rd_data"}, rd_data_o, m_rd);
  endtask

  task automatic nop(int n, string req);
    for (int i = 0; i < n; i++) step(3'd0, 0, 32'hDEAD_0000 + i, 4'h0, req);
  endtask

  task automatic rd(int col, string req);
    step(3'd5, col, 32'h0, 4'h0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_mask = 8'hFF; m_act = 0; m_base = 0; m_cnt = 0; m_rd = '0; m_rdv = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 busy", {31'd0, busy_o}, 32'd0);
    check("R1 rd_valid", {31'd0, rd_valid_o}, 32'd0);
    rd(13, "R1");
    // R2/R3 full bursts from each offset, wrap inside group
    for (int s = 0; s < 4; s++) begin
      step(3'd1, 8 + s * 4 + s, 32'h1111_0000 + s, 4'h0, "R2");
      step(3'd0, 0, 32'h2222_0000 + s, 4'h0, "R2");
      step(3'd0, 0, 32'h3333_0000 + s, 4'h0, "R2");
      step(3'd0, 0, 32'h4444_0000 + s, 4'h0, "R3");
      nop(2, "R3");
      for (int k = 0; k < 4; k++) rd(8 + s * 4 + k, "R2");
    end
    // R4 per-bit mask, then R5 byte mask on top
    step(3'd6, 0, 32'h0000_00A5, 4'h0, "R4");
    step(3'd1, 40, 32'hFFFF_FFFF, 4'h0, "R4");
    nop(3, "R4");
    for (int k = 0; k < 4; k++) rd(40 + k, "R4");
    step(3'd6, 0, 32'h0000_00FF, 4'h0, "R4");
    step(3'd1, 44, 32'h1234_5678, 4'h5, "R5");
    step(3'd0, 0, 32'h9ABC_DEF0, 4'hA, "R5");
    step(3'd0, 0, 32'h0F0F_0F0F, 4'hF, "R5");
    step(3'd0, 0, 32'hCAFE_BABE, 4'h0, "R5");
    for (int k = 0; k < 4; k++) rd(44 + k, "R5");
    // R6 write interrupts write at each beat position
    for (int p = 1; p < 4; p++) begin
      step(3'd1, 48, 32'h5555_0000 + p, 4'h0, "R6");
      nop(p - 1, "R6");
      step(3'd1, 54, 32'h6666_0000 + p, 4'h0, "R6");
      nop(4, "R6");
      for (int k = 48; k < 56; k++) rd(k, "R6");
    end
    // R7 read interrupt, R8 precharge, R10 mask load / unused code
    for (int c = 3; c < 8; c++) begin
      step(3'd1, 56, 32'h7000_0000 + c, 4'h0, "R7");
      step(3'd0, 0, 32'h7100_0000 + c, 4'h0, "R7");
      step(3'(c), 58, 32'h0000_00FF, 4'h0, c == 5 ? "R7" : (c < 5 ? "R8" : "R10"));
      nop(3, "R8");
      for (int k = 56; k < 60; k++) rd(k, "R8");
    end
    // R9 block write during a burst
    step(3'd6, 0, 32'h0000_003C, 4'h0, "R9");
    step(3'd1, 20, 32'h8888_8888, 4'h0, "R9");
    step(3'd2, 61, 32'hFFFF_FFFF, 4'h2, "R9");
    nop(3, "R9");
    for (int k = 60; k < 64; k++) rd(k, "R9");
    rd(21, "R9");
    // mixed random run
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [2:0] c;
      r = $urandom_range(0, 15);
      c = (r < 7) ? 3'd0 : (r < 10) ? 3'd1 : 3'($urandom_range(2, 7));
      step(c, $urandom_range(0, 63), $urandom, 4'($urandom_range(0, 15)), "R2 random");
    end
    for (int k = 0; k < 64; k++) rd(k, "R2 final");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule